// File: doc/BRIEF.md
# Sequential Satisfiability Search Engine

This block decides whether a small Boolean formula in conjunctive normal form has a satisfying assignment. Software or a neighbouring controller first writes the clauses into an internal clause table through a simple write port. Each slot holds up to three literals over sixteen variables, and the table has thirty-two slots. A single-cycle start pulse then launches a depth-first search. The search assigns one variable at a time, derives forced values by unit propagation, detects conflicts, and backtracks chronologically through its own assignment stack.

Propagation scans one clause per cycle. A clause whose literals are all false is a conflict. A clause with no true literal and exactly one unassigned literal forces that literal true, and the forced value is pushed onto the stack as an implication. Passes repeat until a full pass changes nothing. The engine then picks the lowest-numbered free variable and tries it false first. On a conflict it pops implications and flips the most recent decision that has only been tried one way. The run ends when every variable is assigned without conflict, which reports satisfiable. It also ends when the stack empties during backtracking, which reports unsatisfiable; a conflict before any decision is one such case.

Top module: `dpll_solver`

## Requirements
- R1: A write with `wr_en` high while the block is idle stores `wr_data` into the slot at `wr_addr`. Literal k of a slot occupies bits [6k+5:6k]. Within a literal, bits [3:0] are the variable index, bit 4 is the polarity (1: the literal is true when the variable is 1; 0: true when the variable is 0) and bit 5 is the valid flag.
- R2: After reset `busy`, `done` and `sat` are all 0 and every slot is empty.
- R3: A `start` pulse while idle raises `busy` and clears `done` on the next clock edge.
- R4: For a satisfiable formula the run ends with `done` = 1 and `sat` = 1.
- R5: For an unsatisfiable formula the run ends with `done` = 1 and `sat` = 0. This includes formulas whose unit clauses already contradict each other before any decision.
- R6: Literals whose valid flag is 0 are ignored. A slot with no valid literal is ignored, so an empty table is satisfiable.
- R7: `start` while `busy` is high has no effect: the run continues and ends with the same result.
- R8: `done` and `sat` hold their values until the next accepted `start`, and `busy` and `done` are never high together.
- R9: Writes while `busy` is high are discarded. They affect neither the current run nor later runs.
- R10: When a decision leads to a conflict, the engine flips it and keeps searching. A formula that is satisfiable only with the second value of a decision still reports `sat` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Clause write strobe |
| wr_addr | input | 5 | Clause slot index |
| wr_data | input | 18 | Three packed literals |
| start | input | 1 | Launch a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result available |
| sat | output | 1 | 1 satisfiable, 0 unsatisfiable (valid with done) |

## Verification
The bound checker watches the handshake on every cycle. It checks that busy and done are exclusive, that done and sat stay still until a new start, that an idle start raises busy, and that a run leaves busy only by reporting done. The correctness of the verdict can only be shown by the bench's scenarios. These compare each run's result against an exhaustive enumeration of assignments. The scenarios cover immediate contradictions, forced backtracking, ignored literals and slots, the highest variable and slot, and starts and writes issued mid-run.

// File: rtl/dpll_solver.sv
module dpll_solver #(
  parameter int NVARS    = 16,
  parameter int NCLAUSES = 32,
  parameter int LITS     = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [$clog2(NCLAUSES)-1:0]            wr_addr,
  input  logic [LITS*($clog2(NVARS)+2)-1:0]      wr_data,
  input  logic                                   start,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   sat
);
  localparam int VW = $clog2(NVARS);
  localparam int LW = VW + 2;
  localparam int CW = LITS * LW;
  localparam int AW = $clog2(NCLAUSES);
  localparam int SW = $clog2(NVARS + 1);
  localparam int NW = $clog2(LITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_PROP, S_DEC, S_BACK} st_t;
  st_t st;

  logic [CW-1:0]  mem [NCLAUSES];
  logic [NVARS-1:0] asg, val;
  logic [VW-1:0]  tr_var [NVARS];
  logic [NVARS-1:0] tr_dec, tr_flip;
  logic [SW-1:0]  sp;
  logic [AW-1:0]  cp;
  logic           chg;

  logic [CW-1:0]  cl;
  logic           any_valid, any_true;
  logic [NW-1:0]  n_unk;
  logic [VW-1:0]  u_var;
  logic           u_pol;
  logic           any_free;
  logic [VW-1:0]  free_v;
  logic           conflict, unit;
  logic [VW-1:0]  push_i, top_i;

  assign cl     = mem[cp];
  assign busy   = (st != S_IDLE);
  assign push_i = VW'(sp);
  assign top_i  = VW'(sp - 1'b1);

  always_comb begin
    any_valid = 1'b0;
    any_true  = 1'b0;
    n_unk     = '0;
    u_var     = '0;
    u_pol     = 1'b0;
    for (int i = 0; i < LITS; i++) begin
      if (cl[i*LW + LW - 1]) begin
        any_valid = 1'b1;
        if (asg[cl[i*LW +: VW]]) begin
          if (val[cl[i*LW +: VW]] == cl[i*LW + VW]) any_true = 1'b1;
        end else begin
          n_unk = n_unk + 1'b1;
          u_var = cl[i*LW +: VW];
          u_pol = cl[i*LW + VW];
        end
      end
    end
  end

  assign conflict = any_valid && !any_true && (n_unk == '0);
  assign unit     = any_valid && !any_true && (n_unk == NW'(1));

  always_comb begin
    any_free = 1'b0;
    free_v   = '0;
    for (int i = NVARS - 1; i >= 0; i--) begin
      if (!asg[i]) begin
        any_free = 1'b1;
        free_v   = VW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      sat     <= 1'b0;
      asg     <= '0;
      val     <= '0;
      tr_dec  <= '0;
      tr_flip <= '0;
      sp      <= '0;
      cp      <= '0;
      chg     <= 1'b0;
      for (int i = 0; i < NCLAUSES; i++) mem[i] <= '0;
      for (int i = 0; i < NVARS; i++) tr_var[i] <= '0;
    end else begin
      if (wr_en && st == S_IDLE) mem[wr_addr] <= wr_data;
      case (st)
        S_IDLE: if (start) begin
          asg  <= '0;
          sp   <= '0;
          cp   <= '0;
          chg  <= 1'b0;
          done <= 1'b0;
          sat  <= 1'b0;
          st   <= S_PROP;
        end
        S_PROP: begin
          if (conflict) begin
            cp  <= '0;
            chg <= 1'b0;
            st  <= S_BACK;
          end else begin
            if (unit) begin
              asg[u_var]      <= 1'b1;
              val[u_var]      <= u_pol;
              tr_var[push_i]  <= u_var;
              tr_dec[push_i]  <= 1'b0;
              tr_flip[push_i] <= 1'b0;
              sp              <= sp + 1'b1;
            end
            if (cp == AW'(NCLAUSES - 1)) begin
              cp  <= '0;
              chg <= 1'b0;
              st  <= (chg || unit) ? S_PROP : S_DEC;
            end else begin
              cp  <= cp + 1'b1;
              chg <= chg || unit;
            end
          end
        end
        S_DEC: begin
          if (!any_free) begin
            done <= 1'b1;
            sat  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            asg[free_v]     <= 1'b1;
            val[free_v]     <= 1'b0;
            tr_var[push_i]  <= free_v;
            tr_dec[push_i]  <= 1'b1;
            tr_flip[push_i] <= 1'b0;
            sp              <= sp + 1'b1;
            st              <= S_PROP;
          end
        end
        S_BACK: begin
          if (sp == '0) begin
            done <= 1'b1;
            sat  <= 1'b0;
            st   <= S_IDLE;
          end else if (tr_dec[top_i] && !tr_flip[top_i]) begin
            val[tr_var[top_i]] <= 1'b1;
            tr_flip[top_i]     <= 1'b1;
            st                 <= S_PROP;
          end else begin
            asg[tr_var[top_i]] <= 1'b0;
            sp                 <= sp - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpll_solver_chk.sv
module dpll_solver_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sat
);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sat)));

  // R3
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R7
  run_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$rose(busy) && (busy || done));
endmodule

bind dpll_solver dpll_solver_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .sat(sat)
);

// File: tb/dpll_solver_tb.sv
module dpll_solver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        start = 1'b0;
  logic        busy, done, sat;

  int checks = 0;
  int errors = 0;
  bit hold_chk = 1'b0;
  bit hold_sat = 1'b0;
  logic [17:0] shadow [32];

  always #4 clk = ~clk;

  dpll_solver dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done), .sat(sat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(!(busy && done), "R8 busy/done exclusive", int'(busy && done), 0);
    if (hold_chk)
      chk(done === 1'b1 && sat === hold_sat, "R8 result hold", int'(sat), int'(hold_sat));
  end

  function automatic logic [5:0] L(input int v, input bit pol);
    return {1'b1, pol, 4'(v)};
  endfunction

  function automatic bit ref_sat();
    int maxv = 0;
    for (int c = 0; c < 32; c++)
      for (int k = 0; k < 3; k++)
        if (shadow[c][6*k+5] && int'(shadow[c][6*k +: 4]) > maxv) maxv = int'(shadow[c][6*k +: 4]);
    for (int a = 0; a < (1 << (maxv + 1)); a++) begin
      bit ok = 1'b1;
      for (int c = 0; c < 32 && ok; c++) begin
        bit anyv = 1'b0, cs = 1'b0;
        for (int k = 0; k < 3; k++)
          if (shadow[c][6*k+5]) begin
            anyv = 1'b1;
            if (((a >> shadow[c][6*k +: 4]) & 1) == int'(shadow[c][6*k+4])) cs = 1'b1;
          end
        if (anyv && !cs) ok = 1'b0;
      end
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic wrc(input int a, input logic [5:0] l0, input logic [5:0] l1, input logic [5:0] l2);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = {l2, l1, l0}; shadow[a] = {l2, l1, l0};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int a = 0; a < 32; a++) wrc(a, 6'd0, 6'd0, 6'd0);
  endtask

  task automatic launch();
    hold_chk = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R3 start raises busy", int'(busy), 1);
  endtask

  task automatic finish_run(input bit e, input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, {tag, " done reached"}, int'(done), 1);
    chk(sat === e, tag, int'(sat), int'(e));
    hold_sat = e;
    hold_chk = 1'b1;
  endtask

  task automatic run(input bit exp_sat, input string tag);
    bit e = ref_sat();
    chk(e == exp_sat, {tag, " reference"}, int'(e), int'(exp_sat));
    launch();
    finish_run(e, tag);
  endtask

  task automatic all_eight(input int skip);
    int s = 0;
    for (int m = 0; m < 8; m++)
      if (m != skip) begin
        wrc(s, L(0, m[0]), L(1, m[1]), L(2, m[2]));
        s++;
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) shadow[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2
    chk(busy === 1'b0 && done === 1'b0 && sat === 1'b0, "R2 reset state", int'({busy, done, sat}), 0);

    // R6 empty table, R2 slots empty
    run(1'b1, "R6 empty table sat");

    // R6 slot with only invalid literals carrying data bits
    wrc(0, 6'h1f, 6'h10, 6'h0f);
    run(1'b1, "R6 invalid slot ignored");

    // R1 R5 contradicting units, no decision needed
    clear_all();
    wrc(3, L(0, 1'b1), 6'd0, 6'd0);
    wrc(9, L(0, 1'b0), 6'd0, 6'd0);
    run(1'b0, "R5 immediate contradiction");

    // R6 invalid literal inside a clause must not rescue it
    wrc(9, L(0, 1'b0), 6'h11, 6'd0);
    run(1'b0, "R6 invalid literal ignored");

    // R10 first decision fails, flip succeeds
    clear_all();
    wrc(0, L(0, 1'b1), L(1, 1'b1), 6'd0);
    wrc(1, L(0, 1'b1), L(1, 1'b0), 6'd0);
    run(1'b1, "R10 flip decision sat");

    // R5 R10 every sign pattern over three vars
    clear_all();
    all_eight(-1);
    run(1'b0, "R5 full cover unsat");

    // R4 R10 one pattern missing
    clear_all();
    all_eight(5);
    run(1'b1, "R4 seven of eight sat");

    // R1 R5 highest variable and highest slot
    clear_all();
    wrc(31, L(15, 1'b1), 6'd0, 6'd0);
    wrc(0, L(15, 1'b0), L(3, 1'b1), 6'd0);
    wrc(1, L(3, 1'b0), L(15, 1'b0), 6'd0);
    run(1'b0, "R5 var15 slot31 unsat");
    wrc(1, L(3, 1'b1), L(15, 1'b0), 6'd0);
    run(1'b1, "R4 var15 slot31 sat");

    // R4 R5 random three-literal formulas
    for (int f = 0; f < 8; f++) begin
      bit e;
      clear_all();
      for (int c = 0; c < 14; c++)
        wrc(c, L($urandom_range(4), 1'($urandom)), L($urandom_range(4), 1'($urandom)),
               L($urandom_range(4), 1'($urandom)));
      e = ref_sat();
      launch();
      finish_run(e, e ? "R4 random sat" : "R5 random unsat");
    end

    // R7 start while busy
    clear_all();
    all_eight(-1);
    launch();
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy start ignored", int'(busy), 1);
    finish_run(1'b0, "R7 result unchanged");

    // R9 write while busy
    clear_all();
    wrc(0, L(0, 1'b1), L(1, 1'b1), 6'd0);
    launch();
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = {12'd0, L(0, 1'b0)};
    @(negedge clk);
    wr_addr = 5'd6; wr_data = {12'd0, L(1, 1'b0)};
    @(negedge clk);
    wr_en = 1'b0;
    finish_run(1'b1, "R9 busy write ignored in run");
    run(1'b1, "R9 busy write not stored");

    // R8 hold for a while
    repeat (10) @(negedge clk);
    chk(done === 1'b1 && sat === 1'b1, "R8 held after idle", int'(sat), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule